// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

This block is one down-counting timer channel with a pulse-width output. A clock-tree enable (`tick_en`) paces the counting. Software writes two staging registers: a count buffer, which sets the period, and a compare buffer, which sets the duty threshold. The counter and comparator never use these buffers directly. Their values move into the active count and compare registers on only two occasions: when the manual-load control is held, and when the counter reaches its terminal count with auto-reload enabled.

To arm the channel, software sets auto-reload and manual-load together, which copies the buffers across while the counter is held. A single write then raises the run control and drops manual-load, and counting begins. Writing only the compare buffer while the channel runs changes the duty cycle at the next reload and leaves the running count alone. Each terminal count produces a one-cycle interrupt pulse. Without auto-reload, the channel stops at zero. A build parameter removes the waveform output, so the channel can serve as an internal tick timer.

Top module: `dbuf_pwm_channel`

## Requirements
- R1: While `rst_n` is low, both buffers, the active count and the active compare are zero, the channel is idle and `tc_pulse` is 0. With `ctl_invert`=0, `pwm_out` is therefore 1.
- R2: A write to a buffer (`cnt_buf_we` or `cmp_buf_we`) does not change `cur_count` or the active compare in that cycle or the following one.
- R3: On a clock edge with `ctl_load`=1, the active count and compare take the buffer values held before that edge. While `ctl_load` stays 1, no counting takes place, whatever `tick_en` and `ctl_run` are.
- R4: A rising edge of `ctl_run` makes the channel active. While it is active and `ctl_load`=0, every edge with `tick_en`=1 and a nonzero count lowers `cur_count` by 1, visible one cycle later.
- R5: Without `tick_en`, `cur_count` is unchanged.
- R6: A tick at count 0 is a terminal count. One cycle later `tc_pulse` is 1 for that cycle only. With `ctl_reload`=1, the active count and compare reload from the buffers, so the period is count buffer + 1 ticks.
- R7: A terminal count with `ctl_reload`=0 makes the channel idle. The count stays 0 through later ticks until the next rising edge of `ctl_run`.
- R8: With `ctl_run` low, the channel is idle from the next edge on and the count holds.
- R9: `pwm_out` = (`cur_count` <= active compare) XOR `ctl_invert`, taken combinationally from the current state.
- R10: A new compare buffer value changes `pwm_out` only after the next load or reload. The count keeps running meanwhile.
- R11: When built with `HAS_PWM`=0, `pwm_out` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable from the clock tree |
| cnt_buf_we | input | 1 | Write strobe for the count buffer |
| cnt_buf_wdata | input | WIDTH | Count buffer write data |
| cmp_buf_we | input | 1 | Write strobe for the compare buffer |
| cmp_buf_wdata | input | WIDTH | Compare buffer write data |
| ctl_run | input | 1 | Run control; its rising edge starts the channel |
| ctl_load | input | 1 | Manual load of the buffers; holds the counter |
| ctl_reload | input | 1 | Auto-reload at terminal count |
| ctl_invert | input | 1 | Inverts the waveform sense |
| pwm_out | output | 1 | Waveform output |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| cur_count | output | WIDTH | Active count value |

## Verification
Every register result is due one cycle after the edge that consumes its stimulus. `cur_count`, the loaded compare and `tc_pulse` all change on that edge. `pwm_out` follows the new state combinationally, and it follows `ctl_invert` within the same cycle. The bench drives inputs 1 ns after a rising edge and advances its reference model on the next rising edge. It compares all outputs at the falling edge, and its directed checks sample 1 ns after the edge that produced the value.

// File: rtl/dbuf_pwm_pkg.sv
package dbuf_pwm_pkg;
  // What the channel does on a given clock edge
  typedef enum logic [2:0] {
    ACT_HOLD   = 3'd0,
    ACT_LOAD   = 3'd1,
    ACT_DEC    = 3'd2,
    ACT_RELOAD = 3'd3,
    ACT_HALT   = 3'd4
  } chan_act_e;

  localparam int unsigned NUM_BUFS = 2;
  localparam int unsigned BUF_CNT  = 0;
  localparam int unsigned BUF_CMP  = 1;
endpackage

// File: rtl/dbuf_pwm_buffers.sv
module dbuf_pwm_buffers #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_we,
  input  logic [WIDTH-1:0] cnt_wdata,
  input  logic             cmp_we,
  input  logic [WIDTH-1:0] cmp_wdata,
  output logic [WIDTH-1:0] cnt_buf,
  output logic [WIDTH-1:0] cmp_buf
);
  import dbuf_pwm_pkg::*;

  logic             we_v   [NUM_BUFS];
  logic [WIDTH-1:0] wd_v   [NUM_BUFS];
  logic [WIDTH-1:0] buf_q  [NUM_BUFS];

  assign we_v[BUF_CNT] = cnt_we;
  assign wd_v[BUF_CNT] = cnt_wdata;
  assign we_v[BUF_CMP] = cmp_we;
  assign wd_v[BUF_CMP] = cmp_wdata;

  for (genvar i = 0; i < NUM_BUFS; i++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       buf_q[i] <= '0;
      else if (we_v[i]) buf_q[i] <= wd_v[i];
    end
  end

  assign cnt_buf = buf_q[BUF_CNT];
  assign cmp_buf = buf_q[BUF_CMP];
endmodule

// File: rtl/dbuf_pwm_ctrl.sv
module dbuf_pwm_ctrl #(
  parameter int unsigned WIDTH = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_en,
  input  logic                    ctl_run,
  input  logic                    ctl_load,
  input  logic                    ctl_reload,
  input  logic [WIDTH-1:0]        cur_count,
  output dbuf_pwm_pkg::chan_act_e action,
  output logic                    active,
  output logic                    run_rise,
  output logic                    terminal,
  output logic                    tc_pulse
);
  import dbuf_pwm_pkg::*;

  logic run_q;
  logic active_q;
  logic tc_q;

  function automatic chan_act_e pick_action(input logic ld, input logic act,
                                            input logic tick, input logic at_zero,
                                            input logic rld);
    if (ld)                return ACT_LOAD;
    else if (!(act && tick)) return ACT_HOLD;
    else if (!at_zero)     return ACT_DEC;
    else if (rld)          return ACT_RELOAD;
    else                   return ACT_HALT;
  endfunction

  assign action   = pick_action(ctl_load, active_q, tick_en, (cur_count == '0), ctl_reload);
  assign run_rise = ctl_run && !run_q;
  assign terminal = (action == ACT_RELOAD) || (action == ACT_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      active_q <= 1'b0;
      tc_q     <= 1'b0;
    end else begin
      run_q <= ctl_run;
      tc_q  <= terminal;
      if (!ctl_run)               active_q <= 1'b0;
      else if (run_rise)          active_q <= 1'b1;
      else if (action == ACT_HALT) active_q <= 1'b0;
    end
  end

  assign active   = active_q;
  assign tc_pulse = tc_q;
endmodule

// File: rtl/dbuf_pwm_counter.sv
module dbuf_pwm_counter #(
  parameter int unsigned WIDTH = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  dbuf_pwm_pkg::chan_act_e action,
  input  logic [WIDTH-1:0]        cnt_buf,
  input  logic [WIDTH-1:0]        cmp_buf,
  output logic [WIDTH-1:0]        act_count,
  output logic [WIDTH-1:0]        act_compare
);
  import dbuf_pwm_pkg::*;

  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] compare_q;

  function automatic logic [WIDTH-1:0] count_next(input chan_act_e a,
                                                  input logic [WIDTH-1:0] cur,
                                                  input logic [WIDTH-1:0] src);
    case (a)
      ACT_LOAD, ACT_RELOAD: return src;
      ACT_DEC:              return cur - 1'b1;
      default:              return cur;
    endcase
  endfunction

  function automatic logic takes_buffers(input chan_act_e a);
    return (a == ACT_LOAD) || (a == ACT_RELOAD);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      compare_q <= '0;
    end else begin
      count_q <= count_next(action, count_q, cnt_buf);
      if (takes_buffers(action)) compare_q <= cmp_buf;
    end
  end

  assign act_count   = count_q;
  assign act_compare = compare_q;
endmodule

// File: rtl/dbuf_pwm_channel.sv
module dbuf_pwm_channel #(
  parameter int unsigned WIDTH   = 16,
  parameter bit          HAS_PWM = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cnt_buf_we,
  input  logic [WIDTH-1:0] cnt_buf_wdata,
  input  logic             cmp_buf_we,
  input  logic [WIDTH-1:0] cmp_buf_wdata,
  input  logic             ctl_run,
  input  logic             ctl_load,
  input  logic             ctl_reload,
  input  logic             ctl_invert,
  output logic             pwm_out,
  output logic             tc_pulse,
  output logic [WIDTH-1:0] cur_count
);
  import dbuf_pwm_pkg::*;

  logic [WIDTH-1:0] cnt_buf_q;
  logic [WIDTH-1:0] cmp_buf_q;
  logic [WIDTH-1:0] act_cmp;
  chan_act_e        chan_act;
  logic             run_active;
  logic             run_rise;
  logic             terminal_evt;

  function automatic logic duty_level(input logic [WIDTH-1:0] cnt,
                                      input logic [WIDTH-1:0] cmp,
                                      input logic inv);
    return (cnt <= cmp) ^ inv;
  endfunction

  dbuf_pwm_buffers #(.WIDTH(WIDTH)) u_bufs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_we    (cnt_buf_we),
    .cnt_wdata (cnt_buf_wdata),
    .cmp_we    (cmp_buf_we),
    .cmp_wdata (cmp_buf_wdata),
    .cnt_buf   (cnt_buf_q),
    .cmp_buf   (cmp_buf_q)
  );

  dbuf_pwm_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .ctl_run    (ctl_run),
    .ctl_load   (ctl_load),
    .ctl_reload (ctl_reload),
    .cur_count  (cur_count),
    .action     (chan_act),
    .active     (run_active),
    .run_rise   (run_rise),
    .terminal   (terminal_evt),
    .tc_pulse   (tc_pulse)
  );

  dbuf_pwm_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .action      (chan_act),
    .cnt_buf     (cnt_buf_q),
    .cmp_buf     (cmp_buf_q),
    .act_count   (cur_count),
    .act_compare (act_cmp)
  );

  if (HAS_PWM) begin : g_pwm
    assign pwm_out = duty_level(cur_count, act_cmp, ctl_invert);
  end else begin : g_no_pwm
    assign pwm_out = 1'b0;
  end
endmodule

// File: rtl/dbuf_pwm_channel_chk.sv
module dbuf_pwm_channel_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick_en,
  input logic                    ctl_load,
  input logic                    ctl_run,
  input logic [WIDTH-1:0]        cur_count,
  input logic [WIDTH-1:0]        cnt_buf,
  input logic                    tc_pulse,
  input logic                    active,
  input dbuf_pwm_pkg::chan_act_e action
);
  import dbuf_pwm_pkg::*;

  // R3: a manual load moves the count buffer into the counter
  a_r3_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_load |=> cur_count == $past(cnt_buf));

  // R4: a decrement step lowers the count by exactly one
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (action == ACT_DEC) |=> cur_count == $past(cur_count) - 1'b1);

  // R5: no tick and no load leaves the count alone
  a_r5_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ctl_load) |=> $stable(cur_count));

  // R6: the interrupt pulse only follows a tick taken at zero
  a_r6_tc_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> ($past(cur_count) == '0) && $past(tick_en) && !$past(ctl_load));

  // R7: a terminal count without reload leaves the channel idle
  a_r7_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (action == ACT_HALT) |=> !active);

  // R8: dropping the run control idles the channel
  a_r8_run_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_run |=> !active);
endmodule

bind dbuf_pwm_channel dbuf_pwm_channel_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .ctl_load  (ctl_load),
  .ctl_run   (ctl_run),
  .cur_count (cur_count),
  .cnt_buf   (cnt_buf_q),
  .tc_pulse  (tc_pulse),
  .active    (run_active),
  .action    (chan_act)
);

// File: tb/dbuf_pwm_channel_bench.sv
module dbuf_pwm_channel_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, cwe = 0, pwe = 0, run = 0, load = 0, rld = 0, inv = 0;
  logic [W-1:0] cwd = '0, pwd = '0;
  logic pwm, tc, pwm2, tc2;
  logic [W-1:0] cnt, cnt2;

  int n_vec = 0;
  int n_bad = 0;

  // reference model state
  int  m_cbuf, m_pbuf, m_cnt, m_cmp;
  bit  m_act, m_runprev, m_tc;

  always #4 clk = ~clk;

  dbuf_pwm_channel #(.WIDTH(W)) u_dbuf_pwm_channel (
    .clk(clk), .rst_n(rst_n), .tick_en(tick),
    .cnt_buf_we(cwe), .cnt_buf_wdata(cwd), .cmp_buf_we(pwe), .cmp_buf_wdata(pwd),
    .ctl_run(run), .ctl_load(load), .ctl_reload(rld), .ctl_invert(inv),
    .pwm_out(pwm), .tc_pulse(tc), .cur_count(cnt));

  dbuf_pwm_channel #(.WIDTH(W), .HAS_PWM(1'b0)) u_dbuf_pwm_channel_nopwm (
    .clk(clk), .rst_n(rst_n), .tick_en(tick),
    .cnt_buf_we(cwe), .cnt_buf_wdata(cwd), .cmp_buf_we(pwe), .cmp_buf_wdata(pwd),
    .ctl_run(run), .ctl_load(load), .ctl_reload(rld), .ctl_invert(inv),
    .pwm_out(pwm2), .tc_pulse(tc2), .cur_count(cnt2));

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_pwm();
    return ((m_cnt <= m_cmp) ? 1 : 0) ^ int'(inv);
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cbuf = 0; m_pbuf = 0; m_cnt = 0; m_cmp = 0;
      m_act = 0; m_runprev = 0; m_tc = 0;
    end else begin
      bit rise, stop;
      rise = run && !m_runprev;
      stop = 0;
      m_tc = 0;
      if (load) begin
        m_cnt = m_cbuf; m_cmp = m_pbuf;
      end else if (m_act && tick) begin
        if (m_cnt == 0) begin
          m_tc = 1;
          if (rld) begin m_cnt = m_cbuf; m_cmp = m_pbuf; end
          else stop = 1;
        end else m_cnt = m_cnt - 1;
      end
      if (!run) m_act = 0;
      else if (rise) m_act = 1;
      else if (stop) m_act = 0;
      m_runprev = run;
      if (cwe) m_cbuf = int'(cwd);
      if (pwe) m_pbuf = int'(pwd);
    end
  end

  // cycle-by-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 count", int'(cnt), m_cnt);
      chk("R6 tc", int'(tc), int'(m_tc));
      chk("R9 pwm", int'(pwm), model_pwm());
      chk("R11 nopwm", int'(pwm2), 0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    // R1 reset values
    chk("R1 count", int'(cnt), 0);
    chk("R1 tc", int'(tc), 0);
    chk("R1 pwm", int'(pwm), 1);
    rst_n = 1'b1;
    cyc(1);
    // R2 buffer writes do not reach the counter
    cwe = 1; cwd = 5; pwe = 1; pwd = 2;
    cyc(1);
    cwe = 0; pwe = 0;
    chk("R2 count", int'(cnt), 0);
    cyc(1);
    chk("R2 count later", int'(cnt), 0);
    // R3 arm: load with reload
    load = 1; rld = 1;
    cyc(1);
    chk("R3 loaded", int'(cnt), 5);
    tick = 1; run = 1;
    cyc(3);
    chk("R3 held", int'(cnt), 5);
    // R4 start: drop load, keep run
    load = 0;
    cyc(1);
    chk("R4 dec", int'(cnt), 4);
    chk("R9 above", int'(pwm), 0);
    cyc(2);
    chk("R9 at cmp", int'(pwm), 1);
    cyc(2);
    chk("R4 zero", int'(cnt), 0);
    chk("R6 no tc yet", int'(tc), 0);
    cyc(1);
    chk("R6 reload", int'(cnt), 5);
    chk("R6 tc", int'(tc), 1);
    cyc(1);
    chk("R6 tc single", int'(tc), 0);
    chk("R6 count", int'(cnt), 4);
    // R5 hold without ticks
    tick = 0;
    cyc(4);
    chk("R5 hold", int'(cnt), 4);
    // R10 compare change waits for reload
    pwe = 1; pwd = 4;
    cyc(1);
    pwe = 0;
    chk("R10 old cmp", int'(pwm), 0);
    tick = 1;
    cyc(4);
    chk("R10 count", int'(cnt), 0);
    cyc(1);
    chk("R10 reload cnt", int'(cnt), 5);
    chk("R10 reload pwm", int'(pwm), 0);
    cyc(1);
    chk("R10 new cmp", int'(pwm), 1);
    // R9 inversion
    tick = 0; inv = 1;
    cyc(1);
    chk("R9 invert", int'(pwm), 0);
    inv = 0;
    // R8 run low
    tick = 1; run = 0;
    cyc(1);
    chk("R8 last step", int'(cnt), 3);
    cyc(3);
    chk("R8 halted", int'(cnt), 3);
    // R7 one-shot
    rld = 0; load = 1;
    cyc(1);
    chk("R7 loaded", int'(cnt), 5);
    load = 0; run = 1;
    cyc(1);
    chk("R7 start", int'(cnt), 5);
    cyc(5);
    chk("R7 zero", int'(cnt), 0);
    cyc(1);
    chk("R7 tc", int'(tc), 1);
    chk("R7 stays", int'(cnt), 0);
    cyc(4);
    chk("R7 idle count", int'(cnt), 0);
    chk("R7 idle tc", int'(tc), 0);
    // mixed traffic checked by the model
    for (int i = 0; i < 600; i++) begin
      tick = ($urandom % 3) != 0;
      cwe  = ($urandom % 10) == 0;  cwd = W'($urandom % 9);
      pwe  = ($urandom % 8) == 0;   pwd = W'($urandom % 9);
      load = ($urandom % 25) == 0;
      if (($urandom % 30) == 0) run = ~run;
      if (($urandom % 40) == 0) rld = ~rld;
      if (($urandom % 35) == 0) inv = ~inv;
      cyc(1);
    end
    cyc(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule